// File: doc/BRIEF.md
# Bit-Indexed Prefix Address Generator

This block pairs a word-organised register memory with a one-shot prefix stage that turns a packed bit pointer into the operand address of the next bit-test. A prefix command carries an index value and an operand. The index value is one bit-granular pointer across the whole memory: its upper field picks a word and its five low bits pick a bit within that word. The operand carries a table base in its low field and a signed step, counted in bits, in the field above the base. The prefix forms the target word as index word plus base, wrapping within the memory. It keeps the pre-update bit select, and it returns the index advanced by the step as a post-increment.

The target formed by a prefix stays pending until the next bit-test command. That bit-test discards its own word and bit fields and reports a flag equal to the pending bit. The pending state is then dropped. The caller owns the index register. It writes the returned index back into the same register, so that register feeds both the next prefix and the bit select. A separate write port preloads memory words at any time.

Top module: `bitidx_prefix_unit`

## Requirements
- R1: A prefix with index D and operand S sets `pfx_word` to (D[13:5] + S[8:0]) modulo 512 and `pfx_bit` to D[4:0] of the index as it was before the update.
- R2: A prefix returns on `wb_d` the 32-bit sum of D and S[17:9] sign-extended, with wraparound. Bits S[31:18] have no effect on any output.
- R3: A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low for the single cycle after that edge. Exactly one of `wb_valid` (prefix) or `flag_valid` (bit-test) is high for one cycle after the following edge. `cmd_op` is 0 for a prefix and 1 for a bit-test.
- R4: A bit-test taken while `pfx_pending` is high reads the pending word and bit and ignores its own `cmd_d`. `flag` is 1 exactly when that memory bit is 1.
- R5: An accepted bit-test clears `pfx_pending`. A bit-test with no pending prefix uses its own `cmd_d[13:5]` as the word and `cmd_d[4:0]` as the bit.
- R6: A second prefix taken before any bit-test replaces the pending word and bit.
- R7: When `pl_we` is high at a clock edge, `pl_data` is written to word `pl_addr`, whatever the command interface is doing.
- R8: When a preload write and a bit-test read hit the same word on the same edge, the bit-test sees the word's previous contents.
- R9: Reset sets `cmd_ready` high and sets `wb_valid`, `flag_valid` and `pfx_pending` low, which cancels any pending prefix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pl_we | input | 1 | Preload write enable |
| pl_addr | input | 9 | Preload word address |
| pl_data | input | 32 | Preload word data |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_op | input | 1 | 0 = prefix, 1 = bit-test |
| cmd_d | input | 32 | Index value (prefix) or own word/bit fields (bit-test) |
| cmd_s | input | 32 | Operand: base in [8:0], signed bit step in [17:9] |
| wb_valid | output | 1 | Updated index present |
| wb_d | output | 32 | Post-incremented index |
| pfx_pending | output | 1 | A prefix target waits for a bit-test |
| pfx_word | output | 9 | Pending target word |
| pfx_bit | output | 5 | Pending target bit |
| flag_valid | output | 1 | Bit-test result present |
| flag | output | 1 | Value of the tested bit |

## Verification
The preload write port and the bit-test read of the memory can act on the same word in the same cycle. The bench provokes this by raising `pl_we` on the very edge where a bit-test is taken, after first clearing the word and then writing all ones into it. The flag from that bit-test must show the cleared value. A second bit-test of the same word must then show the written value, which proves the write did land.

// File: rtl/bitidx_pkg.sv
package bitidx_pkg;

   // command selector carried on cmd_op
   typedef enum logic {
      OP_PREFIX  = 1'b0,
      OP_BITTEST = 1'b1
   } bix_op_e;

endpackage

// File: rtl/bitidx_mem.sv
module bitidx_mem #(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 9,
   parameter bit READ_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              re,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem_q [DEPTH];
   logic [DATA_W-1:0] rd_q;

   always_ff @(posedge clk) begin
      if (we) mem_q[waddr] <= wdata;
   end

   // variant choice for a read and a write to one word on one edge
   generate
      if (READ_FIRST) begin : g_rd_old
         always_ff @(posedge clk) begin
            if (re) rd_q <= mem_q[raddr];
         end
      end else begin : g_rd_new
         always_ff @(posedge clk) begin
            if (re) rd_q <= (we && (waddr == raddr)) ? wdata : mem_q[raddr];
         end
      end
   endgenerate

   assign rdata = rd_q;

endmodule

// File: rtl/bitidx_addr_calc.sv
module bitidx_addr_calc #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 9,
   parameter int STEP_W = 9
) (
   input  logic [DATA_W-1:0]         idx_in,
   input  logic [DATA_W-1:0]         opnd_in,
   output logic [ADDR_W-1:0]         word_o,
   output logic [$clog2(DATA_W)-1:0] bit_o,
   output logic [DATA_W-1:0]         idx_next_o
);
   localparam int BIT_W = $clog2(DATA_W);
   localparam int EXT_W = DATA_W - STEP_W;

   logic [STEP_W-1:0] step;
   logic [DATA_W-1:0] step_ext;
   logic              unused_opnd_hi;

   assign step     = opnd_in[ADDR_W +: STEP_W];
   assign step_ext = {{EXT_W{step[STEP_W-1]}}, step};

   // word part of the bit pointer plus table base, wrapping in the memory
   assign word_o     = idx_in[BIT_W +: ADDR_W] + opnd_in[ADDR_W-1:0];
   assign bit_o      = idx_in[BIT_W-1:0];
   // post-increment by a bit-granular signed step
   assign idx_next_o = idx_in + step_ext;

   assign unused_opnd_hi = ^opnd_in[DATA_W-1:ADDR_W+STEP_W];

endmodule

// File: rtl/bitidx_prefix_unit.sv
module bitidx_prefix_unit
   import bitidx_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 9,
   parameter int STEP_W     = 9,
   parameter bit READ_FIRST = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      pl_we,
   input  logic [ADDR_W-1:0]         pl_addr,
   input  logic [DATA_W-1:0]         pl_data,
   input  logic                      cmd_valid,
   output logic                      cmd_ready,
   input  logic                      cmd_op,
   input  logic [DATA_W-1:0]         cmd_d,
   input  logic [DATA_W-1:0]         cmd_s,
   output logic                      wb_valid,
   output logic [DATA_W-1:0]         wb_d,
   output logic                      pfx_pending,
   output logic [ADDR_W-1:0]         pfx_word,
   output logic [$clog2(DATA_W)-1:0] pfx_bit,
   output logic                      flag_valid,
   output logic                      flag
);
   localparam int BIT_W = $clog2(DATA_W);

   initial begin : param_chk
      assert (DATA_W == (1 << BIT_W))
         else $error("DATA_W must be a power of two");
      assert (ADDR_W + STEP_W < DATA_W)
         else $error("base and step fields must fit below the top operand bit");
      assert (ADDR_W + BIT_W <= DATA_W)
         else $error("bit pointer must fit in the index word");
   end

   // stage 1: taken command
   logic              s1_valid_q;
   bix_op_e           s1_op_q;
   logic [DATA_W-1:0] s1_d_q;
   logic [DATA_W-1:0] s1_s_q;
   logic [BIT_W-1:0]  s1_bit_q;

   // pending prefix target
   logic              pend_q;
   logic [ADDR_W-1:0] pend_word_q;
   logic [BIT_W-1:0]  pend_bit_q;

   // results
   logic              wb_valid_q;
   logic [DATA_W-1:0] wb_d_q;
   logic              flag_valid_q;
   logic              flag_q;

   logic              accept;
   logic              is_test;
   logic [ADDR_W-1:0] rd_word;
   logic [BIT_W-1:0]  sel_bit;
   logic [DATA_W-1:0] rd_data;
   logic [ADDR_W-1:0] calc_word;
   logic [BIT_W-1:0]  calc_bit;
   logic [DATA_W-1:0] calc_next;

   assign cmd_ready = ~s1_valid_q;
   assign accept    = cmd_valid & cmd_ready;
   assign is_test   = (bix_op_e'(cmd_op) == OP_BITTEST);

   // a pending prefix overrides the bit-test's own fields
   assign rd_word = pend_q ? pend_word_q : cmd_d[BIT_W +: ADDR_W];
   assign sel_bit = pend_q ? pend_bit_q  : cmd_d[BIT_W-1:0];

   bitidx_mem #(
      .DATA_W     (DATA_W),
      .ADDR_W     (ADDR_W),
      .READ_FIRST (READ_FIRST)
   ) i_mem (
      .clk   (clk),
      .we    (pl_we),
      .waddr (pl_addr),
      .wdata (pl_data),
      .re    (accept & is_test),
      .raddr (rd_word),
      .rdata (rd_data)
   );

   bitidx_addr_calc #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W),
      .STEP_W (STEP_W)
   ) i_calc (
      .idx_in     (s1_d_q),
      .opnd_in    (s1_s_q),
      .word_o     (calc_word),
      .bit_o      (calc_bit),
      .idx_next_o (calc_next)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_valid_q   <= 1'b0;
         s1_op_q      <= OP_PREFIX;
         s1_d_q       <= '0;
         s1_s_q       <= '0;
         s1_bit_q     <= '0;
         pend_q       <= 1'b0;
         pend_word_q  <= '0;
         pend_bit_q   <= '0;
         wb_valid_q   <= 1'b0;
         wb_d_q       <= '0;
         flag_valid_q <= 1'b0;
         flag_q       <= 1'b0;
      end else begin
         wb_valid_q   <= 1'b0;
         flag_valid_q <= 1'b0;
         s1_valid_q   <= accept;
         if (accept) begin
            s1_op_q  <= bix_op_e'(cmd_op);
            s1_d_q   <= cmd_d;
            s1_s_q   <= cmd_s;
            s1_bit_q <= sel_bit;
            if (is_test) pend_q <= 1'b0;
         end
         if (s1_valid_q) begin
            if (s1_op_q == OP_PREFIX) begin
               pend_q      <= 1'b1;
               pend_word_q <= calc_word;
               pend_bit_q  <= calc_bit;
               wb_valid_q  <= 1'b1;
               wb_d_q      <= calc_next;
            end else begin
               flag_valid_q <= 1'b1;
               flag_q       <= rd_data[s1_bit_q];
            end
         end
      end
   end

   assign wb_valid    = wb_valid_q;
   assign wb_d        = wb_d_q;
   assign pfx_pending = pend_q;
   assign pfx_word    = pend_word_q;
   assign pfx_bit     = pend_bit_q;
   assign flag_valid  = flag_valid_q;
   assign flag        = flag_q;

   // independent view of the signed step for checking
   logic [DATA_W-1:0] chk_step_ext;
   assign chk_step_ext = {{(DATA_W-STEP_W){cmd_s[ADDR_W+STEP_W-1]}},
                          cmd_s[ADDR_W +: STEP_W]};

   // R3
   ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !cmd_ready ##1 (wb_valid || flag_valid));

   // R3
   one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wb_valid && flag_valid));

   // R2
   idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> (wb_d - $past(cmd_d, 2)) == $past(chk_step_ext, 2));

   // R1
   word_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> (pfx_word == ($past(cmd_d[BIT_W +: ADDR_W], 2)
                                 + $past(cmd_s[ADDR_W-1:0], 2))));

   // R1
   bit_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> pfx_bit == $past(cmd_d[BIT_W-1:0], 2));

   // R5
   pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && is_test) |=> !pfx_pending);

endmodule

// File: tb/test_bitidx_prefix_unit.sv
module test_bitidx_prefix_unit;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 9;

   // prefix vectors: index, operand, expected word, bit, updated index
   localparam logic [31:0] V_D [NV] = '{32'h0, 32'h20, 32'h1F, 32'h3FE3, 32'h5,
                                        32'h40, 32'hFFFF_FFFD, 32'h0001_2345, 32'h20};
   localparam logic [31:0] V_S [NV] = '{32'h0, 32'h231, 32'h205, 32'h2, 32'h3F010,
                                        32'h1FF00, 32'h0, 32'h20007, 32'hFFFC_0231};
   localparam logic [8:0]  V_W [NV] = '{9'h0, 9'h32, 9'h5, 9'h1, 9'h10,
                                        9'h102, 9'h1FF, 9'h121, 9'h32};
   localparam logic [4:0]  V_B [NV] = '{5'd0, 5'd0, 5'd31, 5'd3, 5'd5,
                                        5'd0, 5'd29, 5'd5, 5'd0};
   localparam logic [31:0] V_N [NV] = '{32'h0, 32'h21, 32'h20, 32'h3FE3, 32'hFFFF_FFFD,
                                        32'h13F, 32'hFFFF_FFFD, 32'h0001_2245, 32'h21};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pl_we = 1'b0;
   logic [8:0]  pl_addr = '0;
   logic [31:0] pl_data = '0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic        cmd_op = 1'b0;
   logic [31:0] cmd_d = '0;
   logic [31:0] cmd_s = '0;
   logic        wb_valid;
   logic [31:0] wb_d;
   logic        pfx_pending;
   logic [8:0]  pfx_word;
   logic [4:0]  pfx_bit;
   logic        flag_valid;
   logic        flag;

   int          n_run = 0;
   int          n_fail = 0;
   bit          busy_seen;
   bit          done = 1'b0;
   logic [31:0] model [512];

   always #(CLK_PERIOD/2) clk = ~clk;

   bitidx_prefix_unit i_bitidx_prefix_unit (
      .clk, .rst_n, .pl_we, .pl_addr, .pl_data, .cmd_valid, .cmd_ready,
      .cmd_op, .cmd_d, .cmd_s, .wb_valid, .wb_d, .pfx_pending, .pfx_word,
      .pfx_bit, .flag_valid, .flag
   );

   function automatic logic [31:0] pat(int i);
      return (32'(i) * 32'h9E37_79B9) ^ 32'h5A5A_0F0F;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic preload(input int a, input logic [31:0] v);
      @(negedge clk);
      pl_we = 1'b1; pl_addr = 9'(a); pl_data = v;
      @(negedge clk);
      pl_we = 1'b0;
      model[a] = v;
   endtask

   // drive one command; returns when its result is visible
   task automatic issue(input logic op, input logic [31:0] d, input logic [31:0] s,
                        input bit wr = 1'b0, input int wa = 0,
                        input logic [31:0] wv = '0);
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_d = d; cmd_s = s;
      if (wr) begin pl_we = 1'b1; pl_addr = 9'(wa); pl_data = wv; end
      @(negedge clk);
      busy_seen = !cmd_ready;
      cmd_valid = 1'b0; pl_we = 1'b0;
      cmd_d = 32'h5555_AAAA; cmd_s = 32'hAAAA_5555;
      if (wr) model[wa] = wv;
      @(negedge clk);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin : stim
      logic [31:0] exp_w;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      chk(cmd_ready == 1'b1, "R9", "ready", 32'(cmd_ready), 32'd1);
      chk(wb_valid == 1'b0 && flag_valid == 1'b0, "R9", "valids",
          {30'd0, wb_valid, flag_valid}, 32'd0);
      chk(pfx_pending == 1'b0, "R9", "pending", 32'(pfx_pending), 32'd0);

      // R7 preload the whole memory with a computed pattern
      for (int i = 0; i < 512; i++) preload(i, pat(i));

      // vector table: prefix, then a bit-test whose own fields must be ignored
      for (int v = 0; v < NV; v++) begin
         issue(1'b0, V_D[v], V_S[v]);
         chk(busy_seen, "R3", "ready low after accept", 32'(busy_seen), 32'd1);
         chk(wb_valid && !flag_valid, "R3", "prefix result pulse",
             {30'd0, wb_valid, flag_valid}, 32'd2);
         chk(wb_d == V_N[v], "R2", "updated index", wb_d, V_N[v]);
         chk(pfx_word == V_W[v], "R1", "word", 32'(pfx_word), 32'(V_W[v]));
         chk(pfx_bit == V_B[v], "R1", "bit", 32'(pfx_bit), 32'(V_B[v]));
         @(negedge clk);
         chk(!wb_valid, "R3", "pulse one cycle", 32'(wb_valid), 32'd0);
         chk(pfx_pending, "R4", "pending set", 32'(pfx_pending), 32'd1);
         issue(1'b1, 32'h0000_3FFF, 32'h0);
         exp_w = model[V_W[v]];
         chk(flag_valid && !wb_valid, "R3", "test result pulse",
             {30'd0, wb_valid, flag_valid}, 32'd1);
         chk(flag == exp_w[V_B[v]], "R4", "flag via prefix", 32'(flag), 32'(exp_w[V_B[v]]));
         chk(!pfx_pending, "R5", "pending cleared", 32'(pfx_pending), 32'd0);
      end

      // one-shot override against distinct words
      preload(6, 32'h0);
      preload(7, 32'hFFFF_FFFF);
      issue(1'b1, 32'h0000_00C7, 32'h0);
      chk(flag == 1'b0, "R5", "own fields without prefix", 32'(flag), 32'd0);
      issue(1'b0, 32'h0000_00E0, 32'h0);
      issue(1'b1, 32'h0000_00C0, 32'h0);
      chk(flag == 1'b1, "R4", "own fields ignored", 32'(flag), 32'd1);
      issue(1'b1, 32'h0000_00C0, 32'h0);
      chk(flag == 1'b0, "R5", "override used once", 32'(flag), 32'd0);

      // R6 second prefix replaces the first
      issue(1'b0, 32'h0000_00E0, 32'h0);
      issue(1'b0, 32'h0000_00C4, 32'h0);
      chk(pfx_word == 9'd6 && pfx_bit == 5'd4, "R6", "replaced target",
          {18'd0, pfx_word, pfx_bit}, {18'd0, 9'd6, 5'd4});
      issue(1'b1, 32'h0000_00E0, 32'h0);
      chk(flag == 1'b0, "R6", "test uses newer prefix", 32'(flag), 32'd0);

      // R8 write and read of one word on the same edge
      preload(8, 32'h0);
      issue(1'b1, 32'h0000_010A, 32'h0, 1'b1, 8, 32'hFFFF_FFFF);
      chk(flag == 1'b0, "R8", "old data on collision", 32'(flag), 32'd0);
      issue(1'b1, 32'h0000_010A, 32'h0);
      chk(flag == 1'b1, "R7", "write landed", 32'(flag), 32'd1);

      // R9 reset cancels a pending prefix
      issue(1'b0, 32'h0000_00E0, 32'h0);
      chk(pfx_pending, "R4", "pending before reset", 32'(pfx_pending), 32'd1);
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!pfx_pending && cmd_ready, "R9", "reset clears pending",
          {30'd0, pfx_pending, cmd_ready}, 32'd1);
      issue(1'b1, 32'h0000_00C0, 32'h0);
      chk(flag == 1'b0, "R9", "no override after reset", 32'(flag), 32'd0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule